// File: doc/BRIEF.md
# Register Rename Map with Pinned Writes

This block renames architectural registers of one register class onto a larger pool of physical register tags. It keeps a table indexed by architectural register number and a FIFO of free physical tags. Each accepted rename request returns two tags: the one now assigned to the architectural register and the one that was mapped just before. A commit stage later returns the older tag on the free-tag port once it is no longer needed.

Two cases skip allocation. The first is a configurable zero register, which always keeps its mapping. The second is a pinned mapping. A fresh allocation carries a pin count N. The next N renames of the same architectural register reuse that tag and each lowers the count by one, so a group of consecutive writes shares one physical register. For each physical register the block also stores a writes-to-complete count, loaded as N+1. A lookup port returns the current mapping and both counters.

Top module: `rename_map_pin`

## Requirements
- R1: After reset, architectural register i maps to physical tag i, and the pin and writes-to-complete counters read through the lookup port are 0. The free FIFO holds tags NUM_ARCH through NUM_PHYS-1 and hands them out in ascending order.
- R2: A rename of architectural register ZERO_IDX (default 0) returns the current mapping as both the new and the old tag. It pops nothing and changes no table entry. It is accepted even when the free FIFO is empty.
- R3: In the allocating case, an accepted rename pops the head of the free FIFO, returns it as the new tag and writes it into the table. The mapping held before the rename is returned as the old tag.
- R4: A fresh allocation loads the new tag's pin counter with ren_pin and its writes-to-complete counter with ren_pin+1 (4 bits each).
- R5: If the tag currently mapped to the requested register has a pin counter above 0, the rename returns that tag as both the new and the old tag. It lowers the pin counter by 1 and leaves the free FIFO untouched.
- R6: ren_pin_err is 1 exactly when an accepted rename takes the pinned path with a nonzero ren_pin. It is 0 in every other case.
- R7: ren_ready is 0 only when the request needs an allocation and the free FIFO is empty. Zero-register and pinned renames are accepted regardless.
- R8: A tag returned on the free port joins the FIFO tail in that cycle. It cannot be allocated before the next cycle, and returned tags are later allocated in the order they were returned.
- R9: The lookup port is combinational. A table update made by a rename is seen on the lookup port from the next cycle.
- R10: When ZERO_IDX is 16'hFFFF the class has no zero register, and a rename of architectural register 0 allocates like any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request present |
| ren_areg | input | AREG_W | Architectural register to rename |
| ren_pin | input | 4 | Pin count for a fresh allocation |
| ren_ready | output | 1 | Request can be accepted this cycle |
| ren_new_tag | output | PTAG_W | Physical tag assigned by the rename |
| ren_old_tag | output | PTAG_W | Physical tag mapped before the rename |
| ren_pin_err | output | 1 | Pinned mapping received a nonzero pin count |
| lk_areg | input | AREG_W | Architectural register to look up |
| lk_tag | output | PTAG_W | Current mapping of lk_areg |
| lk_pin | output | 4 | Pin counter of that physical tag |
| lk_wtc | output | 4 | Writes-to-complete counter of that physical tag |
| free_valid | input | 1 | A freed tag is returned |
| free_tag | input | PTAG_W | Tag being returned |

## Verification
A free-tag return and a rename that needs an allocation can arrive in the same cycle. The bench provokes this after draining the FIFO: it returns a tag and requests an allocating rename together. In that cycle ren_ready must stay low, and in the following cycle the rename must receive exactly the returned tag. The bench also issues zero-register and pinned renames while the FIFO is empty, to show that the stall only affects the allocating path.

// File: rtl/rmp_pkg.sv
package rmp_pkg;

    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        PATH_ZERO  = 2'd0,
        PATH_PIN   = 2'd1,
        PATH_ALLOC = 2'd2
    } ren_path_e;

    typedef logic [CNT_W-1:0] cnt_t;

    function automatic cnt_t cnt_dec(input cnt_t c);
        return (c == '0) ? c : c - 1'b1;
    endfunction

endpackage

// File: rtl/rmp_free_fifo.sv
module rmp_free_fifo #(
    parameter int DEPTH     = 16,
    parameter int TAG_W     = 4,
    parameter int INIT_BASE = 8,
    parameter int INIT_CNT  = 8,
    localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    output logic [TAG_W-1:0] head_tag,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [TAG_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_tag = mem[rd_ptr];
    assign empty    = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i < INIT_CNT) ? TAG_W'(INIT_BASE + i) : '0;
            end
            rd_ptr <= '0;
            wr_ptr <= PTR_W'(INIT_CNT % DEPTH);
            count  <= CNT_W'(INIT_CNT);
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_tag;
                wr_ptr      <= wrap_inc(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= wrap_inc(rd_ptr);
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/rmp_map_table.sv
module rmp_map_table
    import rmp_pkg::*;
#(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    parameter int AREG_W   = 3,
    parameter int PTAG_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AREG_W-1:0] rd_areg,
    output logic [PTAG_W-1:0] rd_tag,
    output cnt_t              rd_pin,
    input  logic [AREG_W-1:0] lk_areg,
    output logic [PTAG_W-1:0] lk_tag,
    output cnt_t              lk_pin,
    output cnt_t              lk_wtc,
    input  logic              do_alloc,
    input  logic [PTAG_W-1:0] alloc_tag,
    input  cnt_t              alloc_pin,
    input  logic              do_unpin
);
    logic [PTAG_W-1:0] amap  [NUM_ARCH];
    cnt_t              pin_c [NUM_PHYS];
    cnt_t              wtc_c [NUM_PHYS];

    assign rd_tag = amap[rd_areg];
    assign rd_pin = pin_c[rd_tag];
    assign lk_tag = amap[lk_areg];
    assign lk_pin = pin_c[lk_tag];
    assign lk_wtc = wtc_c[lk_tag];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ARCH; i++) amap[i] <= PTAG_W'(i);
            for (int j = 0; j < NUM_PHYS; j++) begin
                pin_c[j] <= '0;
                wtc_c[j] <= '0;
            end
        end else if (do_alloc) begin
            amap[rd_areg]    <= alloc_tag;
            pin_c[alloc_tag] <= alloc_pin;
            wtc_c[alloc_tag] <= alloc_pin + 1'b1;
        end else if (do_unpin) begin
            pin_c[rd_tag] <= cnt_dec(rd_pin);
        end
    end
endmodule

// File: rtl/rename_map_pin.sv
module rename_map_pin
    import rmp_pkg::*;
#(
    parameter int          NUM_ARCH = 8,
    parameter int          NUM_PHYS = 16,
    parameter logic [15:0] ZERO_IDX = 16'd0,
    localparam int AREG_W = (NUM_ARCH > 1) ? $clog2(NUM_ARCH) : 1,
    localparam int PTAG_W = $clog2(NUM_PHYS),
    localparam int FCNT_W = $clog2(NUM_PHYS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ren_valid,
    input  logic [AREG_W-1:0] ren_areg,
    input  logic [3:0]        ren_pin,
    output logic              ren_ready,
    output logic [PTAG_W-1:0] ren_new_tag,
    output logic [PTAG_W-1:0] ren_old_tag,
    output logic              ren_pin_err,
    input  logic [AREG_W-1:0] lk_areg,
    output logic [PTAG_W-1:0] lk_tag,
    output logic [3:0]        lk_pin,
    output logic [3:0]        lk_wtc,
    input  logic              free_valid,
    input  logic [PTAG_W-1:0] free_tag
);
    localparam bit HAS_ZERO = (ZERO_IDX != 16'hFFFF);

    logic [PTAG_W-1:0] prev_tag, head_tag;
    cnt_t              prev_pin;
    logic              fl_empty, fire;
    logic [FCNT_W-1:0] fl_count;
    ren_path_e         path;

    always_comb begin
        if (HAS_ZERO && (16'(ren_areg) == ZERO_IDX)) path = PATH_ZERO;
        else if (prev_pin != '0)                     path = PATH_PIN;
        else                                         path = PATH_ALLOC;
    end

    assign ren_ready   = !(path == PATH_ALLOC && fl_empty);
    assign fire        = ren_valid && ren_ready;
    assign ren_old_tag = prev_tag;
    assign ren_new_tag = (path == PATH_ALLOC) ? head_tag : prev_tag;
    assign ren_pin_err = fire && (path == PATH_PIN) && (ren_pin != '0);

    rmp_map_table #(
        .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS),
        .AREG_W(AREG_W), .PTAG_W(PTAG_W)
    ) table_i (
        .clk(clk), .rst(rst),
        .rd_areg(ren_areg), .rd_tag(prev_tag), .rd_pin(prev_pin),
        .lk_areg(lk_areg), .lk_tag(lk_tag), .lk_pin(lk_pin), .lk_wtc(lk_wtc),
        .do_alloc(fire && path == PATH_ALLOC), .alloc_tag(head_tag),
        .alloc_pin(ren_pin),
        .do_unpin(fire && path == PATH_PIN)
    );

    rmp_free_fifo #(
        .DEPTH(NUM_PHYS), .TAG_W(PTAG_W),
        .INIT_BASE(NUM_ARCH), .INIT_CNT(NUM_PHYS - NUM_ARCH)
    ) fifo_i (
        .clk(clk), .rst(rst),
        .pop(fire && path == PATH_ALLOC),
        .push(free_valid), .push_tag(free_tag),
        .head_tag(head_tag), .empty(fl_empty), .count(fl_count)
    );
endmodule

// File: rtl/rename_map_pin_chk.sv
module rename_map_pin_chk #(
    parameter int          AREG_W    = 3,
    parameter int          PTAG_W    = 4,
    parameter int          FCNT_W    = 5,
    parameter int          INIT_FREE = 8,
    parameter logic [15:0] ZERO_IDX  = 16'd0
) (
    input logic              clk,
    input logic              rst,
    input logic              ren_valid,
    input logic              ren_ready,
    input logic [AREG_W-1:0] ren_areg,
    input logic [PTAG_W-1:0] ren_new_tag,
    input logic [PTAG_W-1:0] ren_old_tag,
    input logic              ren_pin_err,
    input logic              free_valid,
    input logic [FCNT_W-1:0] fl_count
);
    // R1: free count comes out of reset at its initial value
    assert_reset_free_R1: assert property (@(posedge clk)
        rst |=> fl_count == FCNT_W'(INIT_FREE));

    // R2: zero register keeps its own mapping
    assert_zero_same_R2: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && ren_ready && ZERO_IDX != 16'hFFFF && 16'(ren_areg) == ZERO_IDX)
        |-> ren_new_tag == ren_old_tag);

    // R3: an allocating rename consumes exactly one free tag
    assert_alloc_pops_R3: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && ren_ready && ren_new_tag != ren_old_tag && !free_valid)
        |=> fl_count == $past(fl_count) - 1'b1);

    // R6: error only on an accepted reuse
    assert_pin_err_R6: assert property (@(posedge clk) disable iff (rst)
        ren_pin_err |-> (ren_valid && ren_ready && ren_new_tag == ren_old_tag));

    // R7: the zero register never stalls
    assert_zero_no_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (ZERO_IDX != 16'hFFFF && 16'(ren_areg) == ZERO_IDX) |-> ren_ready);

    // R8: the free count never goes past the number of physical tags
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        fl_count <= FCNT_W'((1 << PTAG_W)));
endmodule

bind rename_map_pin rename_map_pin_chk #(
    .AREG_W(AREG_W), .PTAG_W(PTAG_W), .FCNT_W(FCNT_W),
    .INIT_FREE(NUM_PHYS - NUM_ARCH), .ZERO_IDX(ZERO_IDX)
) chk_i (
    .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_areg(ren_areg), .ren_new_tag(ren_new_tag), .ren_old_tag(ren_old_tag),
    .ren_pin_err(ren_pin_err), .free_valid(free_valid), .fl_count(fl_count)
);

// File: tb/rename_map_pin_tb_top.sv
module rename_map_pin_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       ren_valid = 0, free_valid = 0;
    logic [2:0] ren_areg = 0, lk_areg = 0;
    logic [3:0] ren_pin = 0, free_tag = 0;
    logic       ren_ready, ren_pin_err;
    logic [3:0] ren_new_tag, ren_old_tag, lk_tag, lk_pin, lk_wtc;

    logic       nz_valid = 0;
    logic [2:0] nz_areg = 0;
    logic       nz_ready, nz_err;
    logic [3:0] nz_new, nz_old, nz_lk_tag, nz_lk_pin, nz_lk_wtc;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    rename_map_pin dut_i (
        .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_areg(ren_areg),
        .ren_pin(ren_pin), .ren_ready(ren_ready), .ren_new_tag(ren_new_tag),
        .ren_old_tag(ren_old_tag), .ren_pin_err(ren_pin_err),
        .lk_areg(lk_areg), .lk_tag(lk_tag), .lk_pin(lk_pin), .lk_wtc(lk_wtc),
        .free_valid(free_valid), .free_tag(free_tag)
    );

    rename_map_pin #(.ZERO_IDX(16'hFFFF)) dut_nz (
        .clk(clk), .rst(rst), .ren_valid(nz_valid), .ren_areg(nz_areg),
        .ren_pin(4'd0), .ren_ready(nz_ready), .ren_new_tag(nz_new),
        .ren_old_tag(nz_old), .ren_pin_err(nz_err),
        .lk_areg(nz_areg), .lk_tag(nz_lk_tag), .lk_pin(nz_lk_pin), .lk_wtc(nz_lk_wtc),
        .free_valid(1'b0), .free_tag(4'd0)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one rename cycle; outputs checked before the capturing edge
    task automatic do_ren(input string req, input int areg, input int pin,
                          input bit fv, input int ft, input bit e_rdy,
                          input int e_new, input int e_old, input bit e_err);
        @(negedge clk);
        ren_valid = 1; ren_areg = 3'(areg); ren_pin = 4'(pin);
        free_valid = fv; free_tag = 4'(ft);
        #1;
        chk(req, "ready", int'(ren_ready), int'(e_rdy));
        if (e_rdy) begin
            chk(req, "new_tag", int'(ren_new_tag), e_new);
            chk(req, "old_tag", int'(ren_old_tag), e_old);
        end
        chk(req, "pin_err", int'(ren_pin_err), int'(e_err));
        @(posedge clk); #1;
        ren_valid = 0; free_valid = 0;
    endtask

    task automatic do_lk(input string req, input int areg, input int e_tag,
                         input int e_pin, input int e_wtc);
        @(negedge clk);
        lk_areg = 3'(areg);
        #1;
        chk(req, "lk_tag", int'(lk_tag), e_tag);
        chk(req, "lk_pin", int'(lk_pin), e_pin);
        chk(req, "lk_wtc", int'(lk_wtc), e_wtc);
    endtask

    task automatic t_reset;   // R1
        for (int i = 0; i < 8; i++) do_lk("R1", i, i, 0, 0);
    endtask

    task automatic t_zero;    // R2
        do_ren("R2", 0, 0, 0, 0, 1, 0, 0, 0);
        do_lk("R2", 0, 0, 0, 0);
        do_ren("R2", 1, 0, 0, 0, 1, 8, 1, 0);   // head still 8: zero popped nothing
    endtask

    task automatic t_alloc;   // R3 R4 R9
        do_ren("R3", 1, 0, 0, 0, 1, 9, 8, 0);
        @(negedge clk); lk_areg = 3'd2; #1;
        chk("R9", "lk_tag before rename", int'(lk_tag), 2);
        ren_valid = 1; ren_areg = 3'd2; ren_pin = 0; #1;
        chk("R9", "lk_tag same cycle", int'(lk_tag), 2);
        chk("R3", "new_tag", int'(ren_new_tag), 10);
        @(posedge clk); #1; ren_valid = 0;
        do_lk("R9", 2, 10, 0, 1);
        do_ren("R4", 3, 2, 0, 0, 1, 11, 3, 0);
        do_lk("R4", 3, 11, 2, 3);
    endtask

    task automatic t_pin;     // R5 R6
        do_ren("R5", 3, 0, 0, 0, 1, 11, 11, 0);
        do_lk("R5", 3, 11, 1, 3);
        do_ren("R6", 3, 1, 0, 0, 1, 11, 11, 1);
        do_lk("R5", 3, 11, 0, 3);
        do_ren("R5", 3, 0, 0, 0, 1, 12, 11, 0);
    endtask

    task automatic t_stall;   // R7 R8
        do_ren("R3", 4, 0, 0, 0, 1, 13, 4, 0);
        do_ren("R3", 5, 0, 0, 0, 1, 14, 5, 0);
        do_ren("R4", 6, 1, 0, 0, 1, 15, 6, 0);
        do_ren("R7", 4, 0, 0, 0, 0, 0, 0, 0);
        do_ren("R7", 0, 0, 0, 0, 1, 0, 0, 0);
        do_ren("R7", 6, 0, 0, 0, 1, 15, 15, 0);
        do_ren("R8", 4, 0, 1, 3, 0, 0, 0, 0);
        do_ren("R8", 4, 0, 0, 0, 1, 3, 13, 0);
        do_ren("R7", 7, 0, 0, 0, 0, 0, 0, 0);
        do_ren("R8", 0, 0, 1, 1, 1, 0, 0, 0);
        do_ren("R8", 0, 0, 1, 11, 1, 0, 0, 0);
        do_ren("R8", 5, 0, 0, 0, 1, 1, 14, 0);
        do_ren("R8", 7, 0, 0, 0, 1, 11, 7, 0);
    endtask

    task automatic t_nozero;  // R10
        @(negedge clk); nz_valid = 1; nz_areg = 0; #1;
        chk("R10", "ready", int'(nz_ready), 1);
        chk("R10", "new_tag", int'(nz_new), 8);
        chk("R10", "old_tag", int'(nz_old), 0);
        @(posedge clk); #1; nz_valid = 0;
        @(negedge clk); #1;
        chk("R10", "lk_tag after", int'(nz_lk_tag), 8);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_zero();
        t_alloc();
        t_pin();
        t_stall();
        t_nozero();
        done = 1;
        report();
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule